// File: doc/BRIEF.md
# Byte-Packing Data FIFO

This block buffers 32-bit data words between a host-side data register and a byte-wide card data stream. A 16-entry circular word store sits in the middle. A transfer engine moves a programmed number of bytes between the store and the card stream. In the card-to-host direction, incoming bytes are packed little-endian into words and pushed into the store. In the host-to-card direction, words are popped from the store and sent out a byte at a time, least-significant byte first.

The host sets the byte budget by strobing a load with a block count and a per-block byte length; the budget is their product. The host pushes a word with a write strobe and pops a word with a read strobe; the popped word appears on the read data port one cycle later. The engine moves at most one byte per cycle over a valid/ready handshake. When the budget reaches zero it raises a one-cycle completion pulse, once per load.

Top module: `byte_pack_fifo`

## Requirements
- R1: The store keeps up to 16 words in first-in first-out order, and `fifo_level` equals the number of words held.
- R2: A push (host write or engine) while 16 words are held is discarded: the level stays 16 and the stored words are unchanged.
- R3: `host_rdata` is updated in the cycle after `host_rd` and holds its value otherwise. A pop from an empty store returns zero and leaves the level at zero.
- R4: A `blk_load` strobe sets the remaining byte budget to `blk_num` × `byte_len` and discards any partially packed or partially sent word.
- R5: With `dir_rd`=1, accepted card bytes are packed little-endian. The first byte of each word goes to bits [7:0] and the fourth to bits [31:24]. The word is pushed when its fourth byte is accepted.
- R6: With `dir_rd`=1, if the budget runs out partway through a word, that partial word is pushed with its unfilled upper bytes zero.
- R7: `rx_ready` is low while the store is full, while the budget is zero, or while `host_wr` is high. At most one byte is accepted per cycle.
- R8: With `dir_rd`=0, words leave on `tx_byte` least-significant byte first. Exactly the budgeted number of bytes is sent, and `tx_byte` holds steady while `tx_valid` waits for `tx_ready`.
- R9: With `dir_rd`=0, a transfer of N bytes takes exactly ceil(N/4) words from the store. Any further words stay in order for the host.
- R10: `xfer_done` is high for exactly one cycle, one cycle after the budget reaches zero (a load of zero included). It does not repeat until the next load.
- R11: A host pop and an engine push, or a host push and an engine pop, in the same cycle both take effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Pop one word to `host_rdata` |
| host_wr | input | 1 | Push `host_wdata` |
| host_wdata | input | 32 | Word pushed by the host |
| host_rdata | output | 32 | Last word popped by the host (zero on underflow) |
| blk_load | input | 1 | Load byte budget = `blk_num` × `byte_len` |
| blk_num | input | 9 | Block count |
| byte_len | input | 16 | Bytes per block |
| dir_rd | input | 1 | 1: card to host, 0: host to card |
| rx_byte | input | 8 | Card byte in |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_ready | output | 1 | Engine accepts `rx_byte` this cycle |
| tx_byte | output | 8 | Card byte out |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Card accepts `tx_byte` this cycle |
| fifo_level | output | 5 | Words held, 0 to 16 |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The store has one push port and one pop port, and the host and the engine share them. So the host popping while the engine completes a word, or the host pushing while the engine fetches its next word, lands both operations in one cycle. Random pops during card-to-host transfers, and random pushes during host-to-card transfers with a throttled `tx_ready`, provoke these collisions repeatedly. After every cycle the bench compares `fifo_level` against a count it keeps from the handshakes and strobes it observed, and it compares every word and byte, in order, against streams it computes from the requirements.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    // transfer direction as seen from the host
    typedef enum logic {
        DIR_TO_CARD   = 1'b0,
        DIR_FROM_CARD = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/bpf_store.sv
module bpf_store #(
    parameter int DEPTH = 16,   // power of two
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [LW-1:0] len;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          push_ok, pop_ok;
    logic [PW-1:0] wptr;

    always_comb begin
        full    = (st_q.len == LW'(DEPTH));
        empty   = (st_q.len == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        wptr    = st_q.rptr + st_q.len[PW-1:0];
        head    = mem_q[st_q.rptr];
        level   = st_q.len;
        st_d    = st_q;
        if (pop_ok) begin
            st_d.rptr = st_q.rptr + PW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.len = st_q.len + LW'(1);
            2'b01:   st_d.len = st_q.len - LW'(1);
            default: st_d.len = st_q.len;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wptr] <= push_data;
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/bpf_engine.sv
module bpf_engine #(
    parameter int DW   = 32,
    parameter int CW   = 25,
    localparam int NB  = DW / 8,
    localparam int IW  = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          dir_rd,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    input  logic [7:0]    rx_byte,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [7:0]    tx_byte,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          eng_push,
    output logic [DW-1:0] eng_push_data,
    output logic          eng_pop,
    output logic          done
);
    import bpf_pkg::*;

    typedef struct packed {
        logic [CW-1:0] rem;
        logic [DW-1:0] pack;
        logic [IW-1:0] pidx;
        logic [DW-1:0] shreg;
        logic [IW:0]   lanes;
        logic          armed;
        logic          done;
    } eng_t;

    eng_t e_d, e_q;
    logic [DW-1:0] word_d;
    logic          from_card;

    always_comb begin
        from_card     = (xfer_dir_e'(dir_rd) == DIR_FROM_CARD);
        rx_ready      = from_card && (e_q.rem != '0) && !fifo_full && !host_wr;
        tx_valid      = !from_card && (e_q.rem != '0) && (e_q.lanes != '0);
        tx_byte       = e_q.shreg[7:0];
        word_d        = e_q.pack | (DW'(rx_byte) << {e_q.pidx, 3'b000});
        eng_push      = 1'b0;
        eng_push_data = word_d;
        eng_pop       = 1'b0;
        e_d           = e_q;
        e_d.done      = 1'b0;
        if (load) begin
            e_d.rem   = load_count;
            e_d.pack  = '0;
            e_d.pidx  = '0;
            e_d.lanes = '0;
            e_d.armed = 1'b1;
        end else begin
            if (rx_ready && rx_valid) begin
                e_d.rem = e_q.rem - CW'(1);
                if ((e_q.pidx == IW'(NB - 1)) || (e_q.rem == CW'(1))) begin
                    eng_push = 1'b1;
                    e_d.pack = '0;
                    e_d.pidx = '0;
                end else begin
                    e_d.pack = word_d;
                    e_d.pidx = e_q.pidx + IW'(1);
                end
            end else if (tx_valid && tx_ready) begin
                e_d.rem   = e_q.rem - CW'(1);
                e_d.shreg = e_q.shreg >> 8;
                e_d.lanes = e_q.lanes - (IW + 1)'(1);
            end else if (!from_card && (e_q.rem != '0) && (e_q.lanes == '0)
                         && !fifo_empty && !host_rd) begin
                eng_pop   = 1'b1;
                e_d.shreg = fifo_head;
                e_d.lanes = (IW + 1)'(NB);
            end
            if (e_q.armed && (e_q.rem == '0)) begin
                e_d.done  = 1'b1;
                e_d.armed = 1'b0;
            end
        end
        done = e_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    // R7
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_push |-> !fifo_full);
    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !load) |=> (dir_rd || (tx_valid && $stable(tx_byte))));
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo #(
    parameter int DEPTH  = 16,
    parameter int DW     = 32,
    parameter int BLK_W  = 9,
    parameter int LEN_W  = 16,
    localparam int CW    = BLK_W + LEN_W,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic             blk_load,
    input  logic [BLK_W-1:0] blk_num,
    input  logic [LEN_W-1:0] byte_len,
    input  logic             dir_rd,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    output logic             rx_ready,
    output logic [7:0]       tx_byte,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [LW-1:0]    fifo_level,
    output logic             xfer_done
);
    logic          eng_push, eng_pop;
    logic [DW-1:0] eng_push_data, fifo_head;
    logic          fifo_full, fifo_empty;
    logic          st_push, st_pop;
    logic [DW-1:0] st_push_data;
    logic [CW-1:0] load_count;
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        load_count   = CW'(blk_num) * CW'(byte_len);
        st_push      = host_wr || eng_push;
        st_push_data = eng_push ? eng_push_data : host_wdata;
        st_pop       = host_rd || eng_pop;
        rdata_d      = rdata_q;
        if (host_rd) begin
            rdata_d = fifo_empty ? '0 : fifo_head;
        end
        host_rdata = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    bpf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (st_push),
        .push_data (st_push_data),
        .pop       (st_pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    bpf_engine #(.DW(DW), .CW(CW)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (blk_load),
        .load_count    (load_count),
        .dir_rd        (dir_rd),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .fifo_full     (fifo_full),
        .fifo_empty    (fifo_empty),
        .fifo_head     (fifo_head),
        .rx_byte       (rx_byte),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .tx_byte       (tx_byte),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .eng_push      (eng_push),
        .eng_push_data (eng_push_data),
        .eng_pop       (eng_pop),
        .done          (xfer_done)
    );

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    // R3
    zero_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && fifo_empty) |=> (host_rdata == '0));
endmodule

// File: tb/tb_byte_pack_fifo.sv
module tb_byte_pack_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_rd, host_wr, blk_load, dir_rd;
    logic [31:0] host_wdata, host_rdata;
    logic [8:0]  blk_num;
    logic [15:0] byte_len;
    logic [7:0]  rx_byte, tx_byte;
    logic        rx_valid, rx_ready, tx_valid, tx_ready;
    logic [4:0]  fifo_level;
    logic        xfer_done;

    int total = 0;
    int bad = 0;
    int done_cnt;
    bit rx_hit, tx_hit, pop_hit, wr_hit, stall_seen;
    logic [7:0] got_b[$];

    byte_pack_fifo dut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .blk_load(blk_load),
        .blk_num(blk_num), .byte_len(byte_len), .dir_rd(dir_rd),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .fifo_level(fifo_level), .xfer_done(xfer_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: observe handshakes away from the edge, cross the edge,
    // then observe registered results and clear strobes
    task automatic tick();
        #1;
        rx_hit  = rx_valid && rx_ready;
        tx_hit  = tx_valid && tx_ready;
        pop_hit = host_rd;
        wr_hit  = host_wr;
        if (rx_valid && !rx_ready && fifo_level == 5'd16) stall_seen = 1'b1;
        if (tx_hit) got_b.push_back(tx_byte);
        @(negedge clk);
        #1;
        if (xfer_done) done_cnt++;
        host_rd  = 1'b0;
        host_wr  = 1'b0;
        blk_load = 1'b0;
    endtask

    function automatic logic [31:0] pack_le(input logic [7:0] src[$], input int w, input int n);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++)
            if (w * 4 + b < n) r |= 32'(src[w * 4 + b]) << (8 * b);
        return r;
    endfunction

    task automatic load(input bit rd, input int blocks, input int len);
        dir_rd   = rd;
        blk_num  = 9'(blocks);
        byte_len = 16'(len);
        blk_load = 1'b1;
        done_cnt = 0;
        tick();
    endtask

    // card-to-host transfer; mode 1 withholds host pops to fill the store
    task automatic run_read(input int blocks, input int len, input int mode);
        logic [7:0]  src[$];
        logic [31:0] expw[$];
        int n = blocks * len;
        int idx = 0, k = 0, cyc = 0, lvl = 0, maxl = 0;
        for (int i = 0; i < n; i++) src.push_back(8'($urandom));
        for (int w = 0; w * 4 < n; w++) expw.push_back(pack_le(src, w, n));
        stall_seen = 1'b0;
        load(1'b1, blocks, len);
        while ((idx < n || k < expw.size()) && cyc < 6000) begin
            rx_valid = (idx < n) && ($urandom % 4 != 0);
            rx_byte  = (idx < n) ? src[idx] : 8'h00;
            host_rd  = (fifo_level != 0) && (mode == 0 ? ($urandom % 3 == 0) : (cyc >= 150));
            tick();
            if (rx_hit) begin
                idx++;
                if (idx % 4 == 0 || idx == n) lvl++;
            end
            if (pop_hit) begin
                chk(host_rdata == expw[k], (k * 4 + 4 > n) ? "R6" : "R5",
                    "packed word", host_rdata, expw[k]);
                k++;
                lvl--;
            end
            // R11: concurrent host pop and engine push both counted
            chk(fifo_level == 5'(lvl), "R11", "level during read", 32'(fifo_level), 32'(lvl));
            if (fifo_level > maxl) maxl = fifo_level;
            cyc++;
        end
        rx_valid = 1'b0;
        repeat (3) tick();
        chk(k == expw.size(), "R5", "words delivered", 32'(k), 32'(expw.size()));
        chk(done_cnt == 1, "R10", "done pulses on read", 32'(done_cnt), 32'd1);
        if (mode == 1) begin
            chk(maxl == 16, "R7", "store filled", 32'(maxl), 32'd16);
            chk(stall_seen, "R7", "rx_ready low when full", 32'(stall_seen), 32'd1);
        end
    endtask

    // host-to-card transfer; extra words pushed beyond what the budget needs
    task automatic run_write(input int blocks, input int len, input int extra);
        logic [31:0] words[$];
        logic [7:0]  expb[$];
        int n = blocks * len;
        int need = (n + 3) / 4;
        int nw = need + extra;
        int pushed = 0, cyc = 0;
        for (int i = 0; i < nw; i++) words.push_back($urandom);
        for (int i = 0; i < n; i++) expb.push_back(8'(words[i / 4] >> (8 * (i % 4))));
        got_b.delete();
        load(1'b0, blocks, len);
        while ((got_b.size() < n || pushed < nw) && cyc < 6000) begin
            host_wr    = (pushed < nw) && (fifo_level < 16) && ($urandom % 2 == 0);
            host_wdata = (pushed < nw) ? words[pushed] : 32'h0;
            tx_ready   = ($urandom % 3 != 0);
            tick();
            if (wr_hit) pushed++;
            cyc++;
        end
        tx_ready = 1'b0;
        repeat (3) tick();
        chk(got_b.size() == n, "R8", "byte count sent", 32'(got_b.size()), 32'(n));
        for (int i = 0; i < n && i < got_b.size(); i++)
            chk(got_b[i] == expb[i], "R8", "byte order", 32'(got_b[i]), 32'(expb[i]));
        chk(fifo_level == 5'(extra), "R9", "words left", 32'(fifo_level), 32'(extra));
        chk(done_cnt == 1, "R10", "done pulses on write", 32'(done_cnt), 32'd1);
        for (int j = 0; j < extra; j++) begin
            host_rd = 1'b1;
            tick();
            chk(host_rdata == words[need + j], "R1", "leftover order", host_rdata, words[need + j]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ow[$];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; host_rd = 0; host_wr = 0; host_wdata = 0; blk_load = 0;
        blk_num = 0; byte_len = 0; dir_rd = 0; rx_byte = 0; rx_valid = 0; tx_ready = 0;
        done_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk(fifo_level == 0, "R1", "reset level", 32'(fifo_level), 0);
        chk(host_rdata == 0, "R3", "reset rdata", host_rdata, 0);
        chk(!xfer_done && !rx_ready && !tx_valid, "R10", "reset outputs",
            {29'd0, xfer_done, rx_ready, tx_valid}, 0);

        // overflow: budget is zero so the engine stays idle
        for (int i = 0; i < 17; i++) begin
            ow.push_back($urandom | 32'h1);
            host_wr = 1'b1; host_wdata = ow[i];
            tick();
        end
        chk(fifo_level == 16, "R2", "level after 17 pushes", 32'(fifo_level), 16);
        for (int i = 0; i < 16; i++) begin
            host_rd = 1'b1;
            tick();
            chk(host_rdata == ow[i], "R1", "fifo order", host_rdata, ow[i]);
        end
        // underflow
        host_rd = 1'b1;
        tick();
        chk(host_rdata == 0, "R3", "pop of empty", host_rdata, 0);
        chk(fifo_level == 0, "R3", "level after empty pop", 32'(fifo_level), 0);
        repeat (2) tick();
        chk(host_rdata == 0, "R3", "rdata held", host_rdata, 0);

        // zero budget: no byte accepted, single done
        load(1'b1, 0, 7);
        rx_valid = 1'b1;
        #1;
        chk(!rx_ready, "R7", "rx_ready with zero budget", 32'(rx_ready), 0);
        repeat (12) tick();
        rx_valid = 1'b0;
        chk(done_cnt == 1, "R10", "done after zero load", 32'(done_cnt), 1);
        chk(fifo_level == 0, "R4", "zero budget moved nothing", 32'(fifo_level), 0);

        // host write blocks card bytes
        load(1'b1, 1, 4);
        rx_valid = 1'b1; rx_byte = 8'hA5; host_wr = 1'b1; host_wdata = 32'hCAFE0001;
        #1;
        chk(!rx_ready, "R7", "rx_ready during host write", 32'(rx_ready), 0);
        tick();
        rx_valid = 1'b0;
        host_rd = 1'b1;
        tick();
        chk(host_rdata == 32'hCAFE0001, "R7", "host word kept", host_rdata, 32'hCAFE0001);
        load(1'b1, 0, 0);
        repeat (3) tick();

        // directed transfers
        run_read(1, 7, 0);
        run_read(3, 5, 0);
        run_read(2, 50, 1);
        run_write(2, 5, 2);
        run_write(1, 3, 1);
        run_write(4, 16, 0);
        // new load discards a half-sent word
        run_write(1, 2, 0);

        // random mix
        for (int r = 0; r < 8; r++) begin
            int bl = 1 + $urandom % 4;
            int ln = 1 + $urandom % 13;
            if ($urandom % 2) run_read(bl, ln, 0);
            else run_write(bl, ln, $urandom % 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule